// File: doc/BRIEF.md
# Admin Command Queue Doorbell Engine

This block is the device-side executor for management commands that a host places in a page of shared memory. The host programs the page number of the command array and writes commands into consecutive 64-byte slots. It then rings a doorbell by writing the running total of commands it has submitted. The engine fetches each pending command in slot order and passes its opcode to a stub handler. It writes a status word back into the same slot and then advances a free-running executed-command total. The host polls that total through an event-counter register until it matches its doorbell value.

All register data and command words travel big-endian, so the engine swaps bytes at both its register port and its memory port. Writing zero to the page-number register is a full reset of the engine: the totals are cleared, the doorbell target is dropped and any command in flight is abandoned. The memory port is a simple request port. A read returns data on the cycle after the request, and a write commits at the request edge.

Top module: `aq_engine`

## Requirements
- R1: After reset the page-number, doorbell and event-counter registers read 0, and no memory request is made.
- R2: A doorbell write (register 1) made while the page number is zero is ignored. The doorbell register keeps reading 0, and no memory request follows.
- R3: With a nonzero page number, the engine executes commands until its executed total equals the doorbell value. The event counter (register 2, read-only) reports that total, and the total then stays put.
- R4: Command number n lives at byte address page*4096 + (n mod 64)*64. Its opcode is read from byte offset 0 of the slot, and every memory access stays inside the programmed page.
- R5: The status word is written to byte offset 4 of the command's slot, in the cycle in which the executed total is advanced. Opcodes 1 to 7 give status 0, and any other opcode gives status 0x0000000E.
- R6: Register write and read data and memory command words are big-endian. The value is the byte-reversed 32-bit bus word.
- R7: A doorbell write that arrives during execution replaces the target. Only the newest value is honoured, and no command beyond it is executed.
- R8: Writing 0 to the page-number register (register 0) clears the event counter and the doorbell target and stops execution. No memory request is made until a new page and doorbell are written.
- R9: After 64 commands, the slot index wraps to slot 0 while the executed total keeps counting upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 page number, 1 doorbell, 2 event counter |
| reg_wdata | input | 32 | Register write data, big-endian |
| reg_rdata | output | 32 | Register read data for reg_addr, big-endian |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data, big-endian |
| mem_rdata | input | 32 | Memory read data, valid on the cycle after a read request |

## Verification
The assertions assume three things about the inputs. Memory read data arrives exactly one cycle after a read request. The host only raises the doorbell target above the executed total, never below it. And the totals never come near 32-bit overflow during a run. The bench meets these assumptions. Its memory model answers reads with a fixed latency of one cycle. Every doorbell value it writes is at least the current event count, and a run never goes past a few hundred commands. A reset through the page register is only issued between register writes and is never combined with a doorbell write.

// File: rtl/aq_pkg.sv
package aq_pkg;
  typedef enum logic [1:0] {
    RG_PAGE = 2'd0,
    RG_BELL = 2'd1,
    RG_EVT  = 2'd2
  } reg_sel_e;

  typedef enum logic [1:0] {
    EX_IDLE  = 2'd0,
    EX_FETCH = 2'd1,
    EX_WAIT  = 2'd2,
    EX_STORE = 2'd3
  } ex_state_e;

  function automatic logic [31:0] bswap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction
endpackage

// File: rtl/aq_regs.sv
module aq_regs
  import aq_pkg::*;
#(
  parameter int PFN_W = 20,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [CNT_W-1:0] done_cnt,
  output logic [PFN_W-1:0] page_q,
  output logic [CNT_W-1:0] target_q,
  output logic             page_ok,
  output logic             soft_rst
);
  logic [31:0]      wval;
  logic [PFN_W-1:0] page_d;
  logic [CNT_W-1:0] target_d;
  logic             page_en, target_en;
  logic [31:0]      rval;

  assign wval     = bswap32(reg_wdata);
  assign page_ok  = (page_q != '0);
  assign soft_rst = reg_wr && (reg_addr == RG_PAGE) && (wval == 32'd0);

  always_comb begin
    page_en   = reg_wr && (reg_addr == RG_PAGE);
    page_d    = wval[PFN_W-1:0];
    target_en = soft_rst || (reg_wr && (reg_addr == RG_BELL) && page_ok);
    target_d  = soft_rst ? '0 : wval[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q   <= '0;
      target_q <= '0;
    end else begin
      if (page_en)   page_q   <= page_d;
      if (target_en) target_q <= target_d;
    end
  end

  always_comb begin
    rval = 32'd0;
    case (reg_addr)
      RG_PAGE: rval = 32'(page_q);
      RG_BELL: rval = 32'(target_q);
      RG_EVT:  rval = 32'(done_cnt);
      default: rval = 32'd0;
    endcase
    reg_rdata = bswap32(rval);
  end

  AST_BELL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reg_wr && reg_addr == RG_BELL && !page_ok)) |-> (target_q == $past(target_q))); // R2

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(soft_rst) |-> (target_q == '0 && !page_ok)); // R8
endmodule

// File: rtl/aq_exec.sv
module aq_exec
  import aq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 12,
  parameter int CMD_W    = 6,
  parameter int CNT_W    = 32,
  parameter int STAT_OFS = 4,
  parameter int OPC_LAST = 7,
  parameter logic [31:0] ERR_CODE = 32'h0000_000E,
  localparam int PFN_W  = ADDR_W - PAGE_W,
  localparam int SLOT_W = PAGE_W - CMD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              page_ok,
  input  logic [PFN_W-1:0]  page,
  input  logic [CNT_W-1:0]  target,
  output logic [CNT_W-1:0]  done_cnt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  ex_state_e        st_q, st_d;
  logic [CNT_W-1:0] done_d;
  logic             done_en;
  logic [31:0]      stat_q, stat_d;
  logic             stat_en;
  logic [31:0]      opcode;
  logic [SLOT_W-1:0] slot;
  logic [CMD_W-1:0]  ofs;

  assign opcode = bswap32(mem_rdata);
  assign slot   = done_cnt[SLOT_W-1:0];

  always_comb begin
    st_d    = st_q;
    done_en = 1'b0;
    done_d  = done_cnt + 1'b1;
    stat_en = 1'b0;
    stat_d  = ((opcode != 32'd0) && (opcode <= 32'(OPC_LAST))) ? 32'd0 : ERR_CODE;
    mem_req = 1'b0;
    mem_we  = 1'b0;
    ofs     = '0;
    case (st_q)
      EX_IDLE:  if (page_ok && (done_cnt != target)) st_d = EX_FETCH;
      EX_FETCH: begin
        mem_req = 1'b1;
        st_d    = EX_WAIT;
      end
      EX_WAIT: begin
        stat_en = 1'b1;
        st_d    = EX_STORE;
      end
      EX_STORE: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        ofs     = CMD_W'(STAT_OFS);
        done_en = 1'b1;
        st_d    = EX_IDLE;
      end
      default: st_d = EX_IDLE;
    endcase
    if (soft_rst) begin
      st_d    = EX_IDLE;
      done_en = 1'b1;
      done_d  = '0;
      mem_req = 1'b0;
      mem_we  = 1'b0;
    end
  end

  assign mem_addr  = {page, slot, ofs};
  assign mem_wdata = bswap32(stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= EX_IDLE;
      done_cnt <= '0;
      stat_q   <= '0;
    end else begin
      st_q <= st_d;
      if (done_en) done_cnt <= done_d;
      if (stat_en) stat_q   <= stat_d;
    end
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_cnt == $past(done_cnt)) || (done_cnt == $past(done_cnt) + 1'b1) || (done_cnt == '0)); // R3

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(soft_rst) && (done_cnt != $past(done_cnt))) |-> ($past(done_cnt) != $past(target))); // R7

  AST_STATUS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(soft_rst) && (done_cnt != $past(done_cnt))) |-> $past(mem_req && mem_we)); // R5

  AST_STORE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr[CMD_W-1:0] == CMD_W'(STAT_OFS))); // R5
endmodule

// File: rtl/aq_engine.sv
module aq_engine
  import aq_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PAGE_W   = 12,
  parameter int CMD_W    = 6,
  parameter int CNT_W    = 32,
  parameter int STAT_OFS = 4,
  parameter int OPC_LAST = 7,
  localparam int PFN_W   = ADDR_W - PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  logic [PFN_W-1:0] page_q;
  logic [CNT_W-1:0] target_q;
  logic [CNT_W-1:0] done_cnt;
  logic             page_ok;
  logic             soft_rst;

  aq_regs #(.PFN_W(PFN_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .done_cnt (done_cnt),
    .page_q   (page_q),
    .target_q (target_q),
    .page_ok  (page_ok),
    .soft_rst (soft_rst)
  );

  aq_exec #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .CMD_W(CMD_W), .CNT_W(CNT_W),
    .STAT_OFS(STAT_OFS), .OPC_LAST(OPC_LAST)
  ) u_exec (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .page_ok  (page_ok),
    .page     (page_q),
    .target   (target_q),
    .done_cnt (done_cnt),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  AST_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[ADDR_W-1:PAGE_W] == page_q)); // R4

  AST_QUIET_NO_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    !page_ok |-> !mem_req); // R2
endmodule

// File: tb/tb_aq_engine.sv
module tb_aq_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0, n_bad = 0, n_req = 0, exp_n = 0;
  logic [19:0] cur_page = '0;
  logic [31:0] mem [0:1023];
  logic [31:0] op_tab [0:63];
  localparam logic [31:0] SENT = 32'hDEAD_BEEF;

  always #10 clk = ~clk;

  aq_engine dut (.*);

  function automatic logic [31:0] sw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] exp_stat(input logic [31:0] op);
    return (op >= 1 && op <= 7) ? 32'd0 : 32'h0000_000E;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      n_req++;
      chk(mem_addr[31:12] == cur_page, "R4 page", {12'd0, mem_addr[31:12]}, {12'd0, cur_page});
      if (mem_we) begin
        chk(mem_addr[11:0] == {6'(exp_n % 64), 6'd4}, "R4/R5 status slot order",
            {20'd0, mem_addr[11:0]}, {20'd0, 6'(exp_n % 64), 6'd4});
        chk(mem_wdata == sw(exp_stat(op_tab[exp_n % 64])), "R5/R6 status value",
            mem_wdata, sw(exp_stat(op_tab[exp_n % 64])));
        exp_n <= exp_n + 1;
        mem[mem_addr[11:2]] <= mem_wdata;
      end else begin
        mem_rdata <= mem[mem_addr[11:2]];
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = sw(v);
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) begin
      cur_page = v[19:0];
      if (v == 0) exp_n = 0;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = sw(reg_rdata);
  endtask

  task automatic wait_evt(input int n);
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(2'd2, v);
      if (v == n) break;
    end
  endtask

  task automatic put_cmd(input int s, input logic [31:0] op);
    op_tab[s] = op;
    mem[s*16]     = sw(op);
    mem[s*16 + 1] = SENT;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int base;
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    for (int s = 0; s < 64; s++) put_cmd(s, 32'(s % 16));
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0; mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 page", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 bell", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 event", v, 0);
    chk(n_req == 0, "R1 no request", n_req, 0);

    // R2 doorbell without page
    wr(2'd1, 32'd3);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk(v == 0, "R2 bell ignored", v, 0);
    rd(2'd2, v); chk(v == 0, "R2 event", v, 0);
    chk(n_req == 0, "R2 no request", n_req, 0);

    // R3/R6 basic run, byte order on register read
    wr(2'd0, 32'h0001_2345);
    rd(2'd0, v); chk(v == 32'h0001_2345, "R6 page readback", v, 32'h0001_2345);
    @(negedge clk); reg_addr = 2'd0; #1
    chk(reg_rdata == 32'h4523_0100, "R6 raw bus bytes", reg_rdata, 32'h4523_0100);
    wr(2'd1, 32'd4);
    wait_evt(4);
    rd(2'd2, v); chk(v == 4, "R3 event after 4", v, 4);
    repeat (30) @(negedge clk);
    rd(2'd2, v); chk(v == 4, "R3 holds at target", v, 4);
    chk(mem[4*16 + 1] == SENT, "R3 slot 4 untouched", mem[4*16 + 1], SENT);

    // R7 newest doorbell wins, both raising and lowering while busy
    wr(2'd1, 32'd30);
    wr(2'd1, 32'd9);
    wait_evt(9);
    repeat (40) @(negedge clk);
    rd(2'd2, v); chk(v == 9, "R7 newest target", v, 9);
    chk(mem[9*16 + 1] == SENT, "R7 slot 9 untouched", mem[9*16 + 1], SENT);
    wr(2'd1, 32'd12);
    wr(2'd1, 32'd20);
    wait_evt(20);
    rd(2'd2, v); chk(v == 20, "R7 raised target", v, 20);

    // full sweep of slots and opcodes up to 64
    wr(2'd1, 32'd64);
    wait_evt(64);
    rd(2'd2, v); chk(v == 64, "R3 event at 64", v, 64);
    for (int s = 0; s < 64; s++)
      chk(mem[s*16 + 1] == sw(exp_stat(op_tab[s])), "R5 stored status",
          mem[s*16 + 1], sw(exp_stat(op_tab[s])));

    // R9 wrap to slot 0
    for (int s = 0; s < 6; s++) put_cmd(s, 32'(9 + s * 3));
    wr(2'd1, 32'd70);
    wait_evt(70);
    rd(2'd2, v); chk(v == 70, "R9 event past 64", v, 70);
    for (int s = 0; s < 6; s++)
      chk(mem[s*16 + 1] == sw(exp_stat(op_tab[s])), "R9 wrapped status",
          mem[s*16 + 1], sw(exp_stat(op_tab[s])));

    // R8 reset through page register mid-run
    for (int s = 0; s < 64; s++) put_cmd(s, 32'(1 + s % 7));
    wr(2'd0, 32'd0);
    rd(2'd2, v); chk(v == 0, "R8 event cleared", v, 0);
    wr(2'd0, 32'h0000_0003);
    wr(2'd1, 32'd50);
    repeat (25) @(negedge clk);
    wr(2'd0, 32'd0);
    base = n_req;
    rd(2'd2, v); chk(v == 0, "R8 event after abort", v, 0);
    rd(2'd1, v); chk(v == 0, "R8 bell cleared", v, 0);
    repeat (40) @(negedge clk);
    chk(n_req == base, "R8 quiet after reset", n_req, base);
    for (int s = 0; s < 64; s++) put_cmd(s, (s == 1) ? 32'd200 : 32'd2);
    wr(2'd0, 32'h0000_0003);
    wr(2'd1, 32'd2);
    wait_evt(2);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk(v == 2, "R8 restart count", v, 2);
    chk(mem[16 + 1] == sw(32'h0000_000E), "R5 unknown opcode", mem[17], sw(32'h0000_000E));
    chk(mem[2*16 + 1] == SENT, "R8 restart stops at 2", mem[33], SENT);

    finish_run();
  end
endmodule